// File: doc/BRIEF.md
# Counter Access Permission Checker

This block decides, for one CSR read per cycle, whether a lower-privilege access to a user-level counter, the supervisor timer compare register or the overflow summary register is legal. It holds the three counter-enable registers (machine, supervisor, hypervisor), each 32 bits wide. A write port loads them. The current privilege level and the virtualization bit select one of five run modes: M, HS, HU, VS or VU.

The verdict comes out combinationally as three flags: access allowed, illegal-instruction fault and virtual-instruction fault. For the overflow summary register the block does not trap per counter. Instead it hides each flag bit whose enables the current mode lacks, and presents the masked value. The counters themselves live elsewhere. The per-counter overflow flags are an input.

Top module: `ctr_access_gate`

## Requirements
- R1: After reset all three enable registers read as zero. An HS-mode read of the cycle counter then faults as illegal, and the HS-mode overflow summary view is zero.
- R2: A write with `wr_en_i` high loads `wr_data_i` into the register chosen by `wr_sel_i` (0 machine, 1 supervisor, 2 hypervisor) at the clock edge. Selector value 3 changes no register. Registers not selected keep their value.
- R3: Mode mapping: `priv_i[1]` set is M-mode and `virt_i` is ignored. `priv_i`=01 is HS-mode when `virt_i`=0 and VS-mode when `virt_i`=1. `priv_i`=00 is HU-mode when `virt_i`=0 and VU-mode when `virt_i`=1. In M-mode every recognised address is allowed.
- R4: Counter addresses are 0xC00+n for n=0..31: n=0 cycle, 1 time, 2 instret, 3..31 the event counters. Enable bit n guards counter n. In HS-mode the access is allowed when machine bit n is set and illegal otherwise.
- R5: In HU-mode a counter access is allowed only when both machine and supervisor bit n are set, and is illegal otherwise.
- R6: In VS-mode a counter access is illegal when machine bit n is clear. It is a virtual fault when machine bit n is set and hypervisor bit n is clear. Otherwise it is allowed.
- R7: In VU-mode a counter access is illegal when machine bit n is clear. It is a virtual fault when machine bit n is set and either hypervisor or supervisor bit n is clear. Otherwise it is allowed.
- R8: The timer compare address (default 0x14D) is guarded by bit 1 with the HS and VS rules of R4 and R6. It is always illegal from HU-mode and always a virtual fault from VU-mode.
- R9: At the overflow summary address (default 0xDA0), M-mode, HS-mode and VS-mode are allowed. The view carries overflow flag x in M-mode. In HS-mode it carries flag x only when machine bit x is set. In VS-mode it carries flag x only when machine and hypervisor bits x are both set. Bits 2:0 are always zero.
- R10: At the overflow summary address, HU-mode is illegal, VU-mode is a virtual fault, and the view is zero in both.
- R11: For any other address all three flags are low and the view is zero.
- R12: For a recognised address exactly one of the three flags is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Enable-register write strobe |
| wr_sel_i | input | 2 | Target register: 0 machine, 1 supervisor, 2 hypervisor, 3 none |
| wr_data_i | input | 32 | Value to load |
| csr_addr_i | input | 12 | CSR address being read |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Virtualization mode active |
| ovf_flags_i | input | 32 | Per-counter overflow flags |
| acc_ok_o | output | 1 | Access allowed |
| acc_ill_o | output | 1 | Illegal-instruction fault |
| acc_virt_o | output | 1 | Virtual-instruction fault |
| ovf_view_o | output | 32 | Overflow summary value visible to the current mode |

## Verification
The hardest case to reach is the split verdict in VU-mode. There the machine bit must be set while exactly one of the supervisor or hypervisor bits for the same counter is clear. Uniformly random 32-bit enables hit that only by chance. The stimulus therefore writes directed patterns: machine all ones, with supervisor and hypervisor each covering a different half. The random phase also draws enable words from a small set of dense, sparse and complementary values, so that both the "set with partner clear" combinations and the plain random ones occur at every counter index.

// File: rtl/ctr_gate_pkg.sv
package ctr_gate_pkg;
  typedef enum logic [2:0] {MODE_M, MODE_HS, MODE_HU, MODE_VS, MODE_VU} run_mode_e;
  typedef enum logic [1:0] {CLS_NONE, CLS_CTR, CLS_TCMP, CLS_OVF} csr_class_e;
  typedef enum logic [1:0] {VERD_NONE, VERD_OK, VERD_ILL, VERD_VIRT} verdict_e;

  localparam int NUM_BANKS = 3;

  function automatic run_mode_e mode_of(input logic [1:0] priv, input logic virt);
    run_mode_e m;
    if (priv[1])      m = MODE_M;
    else if (priv[0]) m = virt ? MODE_VS : MODE_HS;
    else              m = virt ? MODE_VU : MODE_HU;
    return m;
  endfunction
endpackage

// File: rtl/ctr_en_bank.sv
module ctr_en_bank #(
  parameter int ENW = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en_i,
  input  logic [1:0]                            wr_sel_i,
  input  logic [ENW-1:0]                        wr_data_i,
  output logic [ctr_gate_pkg::NUM_BANKS-1:0][ENW-1:0] bank_o
);
  import ctr_gate_pkg::*;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic           ld;
    logic [ENW-1:0] bank_d, bank_q;

    always_comb begin
      ld     = wr_en_i && (wr_sel_i == 2'(g));
      bank_d = ld ? wr_data_i : bank_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q <= '0;
      else        bank_q <= bank_d;
    end

    assign bank_o[g] = bank_q;

    // R2: a selected write lands on the next edge
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_sel_i == 2'(g)) |=> (bank_o[g] == $past(wr_data_i)));
    // R2: an unselected bank holds
    p_bank_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && wr_sel_i == 2'(g)) |=> $stable(bank_o[g]));
  end
endmodule

// File: rtl/ctr_csr_decode.sv
module ctr_csr_decode #(
  parameter int          ENW       = 32,
  parameter logic [11:0] CTR_BASE  = 12'hC00,
  parameter logic [11:0] TCMP_ADDR = 12'h14D,
  parameter logic [11:0] OVF_ADDR  = 12'hDA0
) (
  input  logic [11:0]                    addr_i,
  output ctr_gate_pkg::csr_class_e       cls_o,
  output logic [$clog2(ENW)-1:0]         idx_o
);
  import ctr_gate_pkg::*;
  localparam int IDXW = $clog2(ENW);
  localparam logic [IDXW-1:0] TM_BIT = IDXW'(1);

  always_comb begin
    cls_o = CLS_NONE;
    idx_o = addr_i[IDXW-1:0];
    if (addr_i[11:IDXW] == CTR_BASE[11:IDXW]) begin
      cls_o = CLS_CTR;
    end else if (addr_i == TCMP_ADDR) begin
      cls_o = CLS_TCMP;
      idx_o = TM_BIT;
    end else if (addr_i == OVF_ADDR) begin
      cls_o = CLS_OVF;
    end
  end
endmodule

// File: rtl/ctr_perm_rules.sv
module ctr_perm_rules #(
  parameter int ENW = 32
) (
  input  ctr_gate_pkg::csr_class_e cls_i,
  input  logic [$clog2(ENW)-1:0]   idx_i,
  input  ctr_gate_pkg::run_mode_e  mode_i,
  input  logic [ENW-1:0]           m_en_i,
  input  logic [ENW-1:0]           s_en_i,
  input  logic [ENW-1:0]           h_en_i,
  output ctr_gate_pkg::verdict_e   verd_o
);
  import ctr_gate_pkg::*;
  logic mb, sb, hb;

  always_comb begin
    mb = m_en_i[idx_i];
    sb = s_en_i[idx_i];
    hb = h_en_i[idx_i];
    verd_o = VERD_NONE;
    if (cls_i != CLS_NONE) begin
      unique case (mode_i)
        MODE_M:  verd_o = VERD_OK;
        MODE_HS: verd_o = (cls_i == CLS_OVF || mb) ? VERD_OK : VERD_ILL;
        MODE_VS: begin
          if (cls_i == CLS_OVF) verd_o = VERD_OK;
          else if (!mb)         verd_o = VERD_ILL;
          else if (!hb)         verd_o = VERD_VIRT;
          else                  verd_o = VERD_OK;
        end
        MODE_HU: verd_o = (cls_i == CLS_CTR && mb && sb) ? VERD_OK : VERD_ILL;
        MODE_VU: begin
          if (cls_i != CLS_CTR) verd_o = VERD_VIRT;
          else if (!mb)         verd_o = VERD_ILL;
          else if (!hb || !sb)  verd_o = VERD_VIRT;
          else                  verd_o = VERD_OK;
        end
        default: verd_o = VERD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ctr_ovf_view.sv
module ctr_ovf_view #(
  parameter int ENW = 32
) (
  input  ctr_gate_pkg::csr_class_e cls_i,
  input  ctr_gate_pkg::run_mode_e  mode_i,
  input  logic [ENW-1:0]           ovf_i,
  input  logic [ENW-1:0]           m_en_i,
  input  logic [ENW-1:0]           h_en_i,
  output logic [ENW-1:0]           view_o
);
  import ctr_gate_pkg::*;
  localparam int FIRST_HPM = 3;

  for (genvar b = 0; b < ENW; b++) begin : g_bit
    if (b < FIRST_HPM) begin : g_zero
      assign view_o[b] = 1'b0;
    end else begin : g_mask
      logic vis;
      always_comb begin
        unique case (mode_i)
          MODE_M:  vis = 1'b1;
          MODE_HS: vis = m_en_i[b];
          MODE_VS: vis = m_en_i[b] & h_en_i[b];
          default: vis = 1'b0;
        endcase
      end
      assign view_o[b] = (cls_i == CLS_OVF) & vis & ovf_i[b];
    end
  end
endmodule

// File: rtl/ctr_access_gate.sv
module ctr_access_gate #(
  parameter int          ENW       = 32,
  parameter logic [11:0] CTR_BASE  = 12'hC00,
  parameter logic [11:0] TCMP_ADDR = 12'h14D,
  parameter logic [11:0] OVF_ADDR  = 12'hDA0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_sel_i,
  input  logic [ENW-1:0] wr_data_i,
  input  logic [11:0]    csr_addr_i,
  input  logic [1:0]     priv_i,
  input  logic           virt_i,
  input  logic [ENW-1:0] ovf_flags_i,
  output logic           acc_ok_o,
  output logic           acc_ill_o,
  output logic           acc_virt_o,
  output logic [ENW-1:0] ovf_view_o
);
  import ctr_gate_pkg::*;
  localparam int IDXW = $clog2(ENW);

  logic [NUM_BANKS-1:0][ENW-1:0] bank;
  csr_class_e                    cls;
  logic [IDXW-1:0]               idx;
  run_mode_e                     mode;
  verdict_e                      verd;

  assign mode = mode_of(priv_i, virt_i);

  ctr_en_bank #(.ENW(ENW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .bank_o(bank));

  ctr_csr_decode #(.ENW(ENW), .CTR_BASE(CTR_BASE), .TCMP_ADDR(TCMP_ADDR),
                   .OVF_ADDR(OVF_ADDR)) u_dec (
    .addr_i(csr_addr_i), .cls_o(cls), .idx_o(idx));

  ctr_perm_rules #(.ENW(ENW)) u_rules (
    .cls_i(cls), .idx_i(idx), .mode_i(mode), .m_en_i(bank[0]),
    .s_en_i(bank[1]), .h_en_i(bank[2]), .verd_o(verd));

  ctr_ovf_view #(.ENW(ENW)) u_view (
    .cls_i(cls), .mode_i(mode), .ovf_i(ovf_flags_i), .m_en_i(bank[0]),
    .h_en_i(bank[2]), .view_o(ovf_view_o));

  always_comb begin
    acc_ok_o   = (verd == VERD_OK);
    acc_ill_o  = (verd == VERD_ILL);
    acc_virt_o = (verd == VERD_VIRT);
  end

  // R12: a recognised address yields exactly one flag
  p_one_verdict_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cls != CLS_NONE) |-> $onehot({acc_ok_o, acc_ill_o, acc_virt_o}));
  // R11: unrecognised address raises nothing
  p_quiet_other_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_NONE) |-> ({acc_ok_o, acc_ill_o, acc_virt_o} == 3'b000 && ovf_view_o == '0));
  // R3: machine mode never faults
  p_machine_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    priv_i[1] |-> !(acc_ill_o || acc_virt_o));
  // R4: HS counter read with machine bit clear is illegal
  p_hs_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_CTR && priv_i == 2'b01 && !virt_i && !bank[0][idx]) |-> acc_ill_o);
  // R9: low summary bits stay zero and view never invents a flag
  p_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_view_o[2:0] == 3'b000) && ((ovf_view_o & ~ovf_flags_i) == '0));
  // R10: user modes see an empty summary
  p_user_blind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'b00) |-> (ovf_view_o == '0));
endmodule

// File: tb/ctr_access_gate_test.sv
`timescale 1ns/100ps
module ctr_access_gate_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [11:0] addr;
  logic [1:0]  priv;
  logic        virt;
  logic [31:0] ovf;
  logic        ok, ill, vill;
  logic [31:0] view;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;
  logic [31:0] m_m, m_s, m_h;

  always #2.5 clk = ~clk;

  ctr_access_gate uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .csr_addr_i(addr), .priv_i(priv), .virt_i(virt),
    .ovf_flags_i(ovf), .acc_ok_o(ok), .acc_ill_o(ill), .acc_virt_o(vill),
    .ovf_view_o(view));

  // Expected {ok, ill, virt, view} from the requirements
  function automatic logic [34:0] expect_of(input logic [11:0] a, input logic [1:0] p,
                                            input logic v, input logic [31:0] fl);
    int kind; int i; int md; logic mb, sb, hb; logic [2:0] f; logic [31:0] vw;
    kind = 0; i = 0; f = 3'b000; vw = '0;
    if (a[11:5] == 7'h60) begin kind = 1; i = int'(a[4:0]); end
    else if (a == 12'h14D) begin kind = 2; i = 1; end
    else if (a == 12'hDA0) kind = 3;
    if (p[1]) md = 0; else if (p[0]) md = v ? 3 : 1; else md = v ? 4 : 2;
    mb = m_m[i]; sb = m_s[i]; hb = m_h[i];
    if (kind != 0) begin
      case (md)
        0: f = 3'b100;
        1: f = (kind == 3 || mb) ? 3'b100 : 3'b010;
        3: f = (kind == 3) ? 3'b100 : (!mb ? 3'b010 : (!hb ? 3'b001 : 3'b100));
        2: f = (kind == 1 && mb && sb) ? 3'b100 : 3'b010;
        default: f = (kind != 1) ? 3'b001 : (!mb ? 3'b010 : ((!hb || !sb) ? 3'b001 : 3'b100));
      endcase
      if (kind == 3) begin
        case (md)
          0: vw = fl;
          1: vw = fl & m_m;
          3: vw = fl & m_m & m_h;
          default: vw = '0;
        endcase
        vw[2:0] = 3'b000;
      end
    end
    return {f, vw};
  endfunction

  task automatic do_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    case (sel)
      2'd0: m_m = d;
      2'd1: m_s = d;
      2'd2: m_h = d;
      default: ;
    endcase
  endtask

  task automatic probe(input logic [11:0] a, input logic [1:0] p, input logic v,
                       input logic [31:0] fl, input string req);
    logic [34:0] e;
    @(negedge clk);
    addr = a; priv = p; virt = v; ovf = fl;
    #1;
    e = expect_of(a, p, v, fl);
    vectors++;
    if ({ok, ill, vill, view} !== e) begin
      misses++;
      $display("FAIL %s addr=%h priv=%b virt=%b got ok/ill/virt=%b%b%b view=%h exp %b view=%h",
               req, a, p, v, ok, ill, vill, view, e[34:32], e[31:0]);
    end
  endtask

  function automatic logic [31:0] pick_word();
    case ($urandom_range(0, 5))
      0: return 32'hFFFF_FFFF;
      1: return 32'h0000_0000;
      2: return 32'hAAAA_AAAA;
      3: return 32'h5555_5555;
      4: return 32'h0000_FFFF;
      default: return $urandom();
    endcase
  endfunction

  function automatic logic [11:0] pick_addr();
    case ($urandom_range(0, 7))
      0, 1, 2, 3: return 12'hC00 | 12'($urandom_range(0, 31));
      4: return 12'h14D;
      5: return 12'hDA0;
      default: return 12'($urandom());
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    m_m = '0; m_s = '0; m_h = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    addr = '0; priv = 2'b11; virt = 1'b0; ovf = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    probe(12'hC00, 2'b01, 1'b0, 32'hFFFF_FFFF, "R1");
    probe(12'hDA0, 2'b01, 1'b0, 32'hFFFF_FFFF, "R1");
    // R3 machine mode, including priv 2'b10 and virt ignored
    probe(12'hC1F, 2'b11, 1'b1, 32'h0, "R3");
    probe(12'h14D, 2'b10, 1'b0, 32'h0, "R3");
    probe(12'hDA0, 2'b11, 1'b0, 32'hFFFF_FFFF, "R9");
    // R2 selector 3 writes nothing
    do_write(2'd3, 32'hFFFF_FFFF);
    probe(12'hC05, 2'b01, 1'b0, 32'h0, "R2");
    // VU split cases: machine all, supervisor low half, hypervisor high half
    do_write(2'd0, 32'hFFFF_FFFF);
    do_write(2'd1, 32'h0000_FFFF);
    do_write(2'd2, 32'hFFFF_0000);
    probe(12'hC04, 2'b00, 1'b1, 32'h0, "R7");
    probe(12'hC14, 2'b00, 1'b1, 32'h0, "R7");
    probe(12'hC04, 2'b00, 1'b0, 32'h0, "R5");
    probe(12'hC14, 2'b00, 1'b0, 32'h0, "R5");
    probe(12'hC04, 2'b01, 1'b1, 32'h0, "R6");
    probe(12'hC14, 2'b01, 1'b1, 32'h0, "R6");
    probe(12'h14D, 2'b01, 1'b1, 32'h0, "R8");
    probe(12'h14D, 2'b00, 1'b0, 32'h0, "R8");
    probe(12'h14D, 2'b00, 1'b1, 32'h0, "R8");
    probe(12'hDA0, 2'b01, 1'b1, 32'hFFFF_FFFF, "R9");
    probe(12'hDA0, 2'b00, 1'b1, 32'hFFFF_FFFF, "R10");
    probe(12'hDA0, 2'b00, 1'b0, 32'hFFFF_FFFF, "R10");
    probe(12'hC20, 2'b01, 1'b0, 32'hFFFF_FFFF, "R11");
    probe(12'hBFF, 2'b00, 1'b1, 32'hFFFF_FFFF, "R11");
    // R4 machine bit cleared for one counter
    do_write(2'd0, 32'hFFFF_FFF7);
    probe(12'hC03, 2'b01, 1'b0, 32'h0, "R4");
    probe(12'hC03, 2'b00, 1'b1, 32'h0, "R7");
    probe(12'hDA0, 2'b01, 1'b0, 32'hFFFF_FFFF, "R9");

    // Random phase covering R2..R12
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) == 0)
        do_write(2'($urandom_range(0, 3)), pick_word());
      probe(pick_addr(), 2'($urandom()), 1'($urandom()), $urandom(), "R12");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule